// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Aggregator

This block gathers single-cycle event pulses from a removable storage-card host interface and a request from a neighbouring sibling controller, and folds them onto one interrupt line. At the first level, card events are latched in a local pending register. Software clears a pending bit by writing 1 to it. A local enable register decides which pending bits count toward a one-bit local summary.

At the second level, a global pending register holds two summary bits: bit 0 for the card interface and bit 1 for the sibling. A global record mask decides whether a summary may latch into the global pending register at all. A separate global signal mask decides whether a latched global bit may drive the output line. The output is taken from a flop, so it cannot glitch. The expected software sequence is to clear a pending local bit before it enables that bit, so that no stale event fires.

Top module: `irq_cascade`

## Requirements
- R1: While reset is low and on the first cycle after it, every register reads 0 and `irqOut` is low.
- R2: A pulse on `cardEvt[b]` sets local pending bit b at the next clock edge, for the implemented positions b = 0, 1, 2, 3, 8, 9, 10, 11. Positions 4 to 7 always read 0 and ignore events.
- R3: Writing the local pending register (address 0) clears each implemented bit whose write-data bit is 1 and leaves every bit whose write-data bit is 0 unchanged.
- R4: If an event pulse and a write-1 clear hit the same local bit in the same cycle, the bit remains set.
- R5: Global pending bit 0 sets one cycle after any bit of (local pending AND local enable) is 1, but only while global record mask bit 0 is 1. While that mask bit is 0, the global bit does not set.
- R6: Global pending bit 1 sets one cycle after `sibReq` is high, but only while global record mask bit 1 is 1.
- R7: Writing the global pending register (address 2) with a 1 in a bit clears that bit. A bit whose source is still active in the same cycle stays set.
- R8: `irqOut` equals the OR of (global pending AND global signal mask) as it stood one cycle earlier.
- R9: Reading any register has no side effect. `rdData` shows the register at `addr` combinationally, and no register changes because of a read.
- R10: Register map: 0 local pending, 1 local enable (positions 4 to 7 are not writable and read 0), 2 global pending, 3 global record mask, 4 global signal mask. These registers use data bits [11:0] or [1:0]. Upper data bits read 0. Addresses 5 to 7 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe for this cycle |
| addr | input | 3 | Register word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` |
| cardEvt | input | 12 | Card interface event pulses, one per position |
| sibReq | input | 1 | Sibling controller request |
| irqOut | output | 1 | Registered interrupt line |

## Verification
Two functions can land in the same cycle: an incoming event or source, and a software write-1 clear of the very same bit. This can happen both at the local level and at the global level. The bench provokes it by raising `cardEvt` on a bit in the same cycle as a clear of that bit. It also clears global bit 0 while its local cause is still enabled and pending. It judges the result by reading the register back, expecting the bit to survive (R4, R7). A random phase then mixes writes, pulses and sibling requests so that such coincidences recur.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int ADDR_W = 3;
  localparam int GLO_W  = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_LOC_STS    = 3'd0,
    A_LOC_EN     = 3'd1,
    A_GLO_STS    = 3'd2,
    A_GLO_STS_EN = 3'd3,
    A_GLO_SIG_EN = 3'd4
  } regAddr_e;

  typedef struct packed {
    logic wrLocSts;
    logic wrLocEn;
    logic wrGloSts;
    logic wrGloStsEn;
    logic wrGloSigEn;
  } regStrobe_t;
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output regStrobe_t        strb
);
  always_comb begin
    strb = '0;
    if (wrEn) begin
      case (addr)
        A_LOC_STS:    strb.wrLocSts   = 1'b1;
        A_LOC_EN:     strb.wrLocEn    = 1'b1;
        A_GLO_STS:    strb.wrGloSts   = 1'b1;
        A_GLO_STS_EN: strb.wrGloStsEn = 1'b1;
        A_GLO_SIG_EN: strb.wrGloSigEn = 1'b1;
        default:      strb = '0;
      endcase
    end
  end
endmodule

// File: rtl/irqc_dpath.sv
module irqc_dpath
  import irqc_pkg::*;
#(
  parameter int               LOC_W    = 12,
  parameter logic [LOC_W-1:0] LOC_MASK = 12'hF0F
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       strb,
  input  logic [LOC_W-1:0] wrData,
  input  logic [LOC_W-1:0] cardEvt,
  input  logic             sibReq,
  output logic [LOC_W-1:0] locSts,
  output logic [LOC_W-1:0] locEn,
  output logic [GLO_W-1:0] gloSts,
  output logic [GLO_W-1:0] gloStsEn,
  output logic [GLO_W-1:0] gloSigEn,
  output logic             irqOut
);
  logic [LOC_W-1:0] locClr;
  logic [GLO_W-1:0] gloClr;
  logic [GLO_W-1:0] gloSrc;
  logic             locSummary;
  logic             unusedBits;

  assign locClr     = strb.wrLocSts ? wrData : '0;
  assign gloClr     = strb.wrGloSts ? wrData[GLO_W-1:0] : '0;
  assign unusedBits = ^(cardEvt & ~LOC_MASK) ^ ^(wrData & ~LOC_MASK);

  // local level: one flop pair per implemented position
  for (genvar i = 0; i < LOC_W; i++) begin : gLoc
    if (LOC_MASK[i]) begin : gImpl
      logic stsQ;
      logic enQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)           stsQ <= 1'b0;
        else if (cardEvt[i]) stsQ <= 1'b1;
        else if (locClr[i])  stsQ <= 1'b0;
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             enQ <= 1'b0;
        else if (strb.wrLocEn) enQ <= wrData[i];
      end
      assign locSts[i] = stsQ;
      assign locEn[i]  = enQ;
    end else begin : gTie
      assign locSts[i] = 1'b0;
      assign locEn[i]  = 1'b0;
    end
  end

  assign locSummary = |(locSts & locEn);
  assign gloSrc     = {sibReq, locSummary} & gloStsEn;

  // global level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gloSts   <= '0;
      gloStsEn <= '0;
      gloSigEn <= '0;
      irqOut   <= 1'b0;
    end else begin
      gloSts <= (gloSts & ~gloClr) | gloSrc;
      if (strb.wrGloStsEn) gloStsEn <= wrData[GLO_W-1:0];
      if (strb.wrGloSigEn) gloSigEn <= wrData[GLO_W-1:0];
      irqOut <= |(gloSts & gloSigEn);
    end
  end
endmodule

// File: rtl/irq_cascade.sv
module irq_cascade
  import irqc_pkg::*;
#(
  parameter int               DATA_W   = 32,
  parameter int               LOC_W    = 12,
  parameter logic [LOC_W-1:0] LOC_MASK = 12'hF0F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [LOC_W-1:0]  cardEvt,
  input  logic              sibReq,
  output logic              irqOut
);
  regStrobe_t       strb;
  logic [LOC_W-1:0] locSts;
  logic [LOC_W-1:0] locEn;
  logic [GLO_W-1:0] gloSts;
  logic [GLO_W-1:0] gloStsEn;
  logic [GLO_W-1:0] gloSigEn;
  logic             unusedHi;

  assign unusedHi = ^wrData[DATA_W-1:LOC_W];

  irqc_ctrl uCtrl (
    .wrEn (wrEn),
    .addr (addr),
    .strb (strb)
  );

  irqc_dpath #(.LOC_W(LOC_W), .LOC_MASK(LOC_MASK)) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (wrData[LOC_W-1:0]),
    .cardEvt  (cardEvt),
    .sibReq   (sibReq),
    .locSts   (locSts),
    .locEn    (locEn),
    .gloSts   (gloSts),
    .gloStsEn (gloStsEn),
    .gloSigEn (gloSigEn),
    .irqOut   (irqOut)
  );

  always_comb begin
    rdData = '0;
    case (addr)
      A_LOC_STS:    rdData[LOC_W-1:0] = locSts;
      A_LOC_EN:     rdData[LOC_W-1:0] = locEn;
      A_GLO_STS:    rdData[GLO_W-1:0] = gloSts;
      A_GLO_STS_EN: rdData[GLO_W-1:0] = gloStsEn;
      A_GLO_SIG_EN: rdData[GLO_W-1:0] = gloSigEn;
      default:      rdData = '0;
    endcase
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
  import irqc_pkg::*;
#(
  parameter int               LOC_W    = 12,
  parameter logic [LOC_W-1:0] LOC_MASK = 12'hF0F
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [LOC_W-1:0]  wrData,
  input logic [LOC_W-1:0]  cardEvt,
  input logic              sibReq,
  input logic [LOC_W-1:0]  locSts,
  input logic [LOC_W-1:0]  locEn,
  input logic [GLO_W-1:0]  gloSts,
  input logic [GLO_W-1:0]  gloStsEn,
  input logic [GLO_W-1:0]  gloSigEn,
  input logic              irqOut
);
  logic [LOC_W-1:0] clrMask;
  logic [LOC_W-1:0] evtM;
  logic             gloClr0;

  assign clrMask = (wrEn && addr == 3'd0) ? wrData : '0;
  assign evtM    = cardEvt & LOC_MASK;
  assign gloClr0 = wrEn && addr == 3'd2 && wrData[0];

  // R3
  loc_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(clrMask & ~cardEvt)) |=> ((locSts & $past(clrMask & ~cardEvt)) == '0));

  // R4
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(clrMask & evtM)) |=> ((locSts & $past(clrMask & evtM)) == $past(clrMask & evtM)));

  // R5
  loc_summary_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((|(locSts & locEn)) && gloStsEn[0]) |=> gloSts[0]);

  // R6
  sib_record_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sibReq && gloStsEn[1]) |=> gloSts[1]);

  // R7
  glo_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gloSts[0] && !gloClr0) |=> gloSts[0]);

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(|(gloSts & gloSigEn)) |=> !irqOut);

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(|(gloSts & gloSigEn)));
endmodule

bind irq_cascade irqc_chk #(.LOC_W(LOC_W), .LOC_MASK(LOC_MASK)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .addr     (addr),
  .wrData   (wrData[LOC_W-1:0]),
  .cardEvt  (cardEvt),
  .sibReq   (sibReq),
  .locSts   (locSts),
  .locEn    (locEn),
  .gloSts   (gloSts),
  .gloStsEn (gloStsEn),
  .gloSigEn (gloSigEn),
  .irqOut   (irqOut)
);

// File: tb/sim_irq_cascade.sv
module sim_irq_cascade;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [11:0] cardEvt = '0;
  logic        sibReq = 1'b0;
  logic        irqOut;

  int    checks = 0;
  int    errors = 0;
  string curReq = "R1";
  bit    done = 1'b0;

  // behavioural reference state
  bit [11:0] mLoc, mEn;
  bit [1:0]  mGlo, mGse, mSig;
  bit        mIrq;

  always #5 clk = ~clk;

  irq_cascade u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .cardEvt(cardEvt), .sibReq(sibReq), .irqOut(irqOut)
  );

  function automatic bit implemented(int b);
    return (b < 4) || (b >= 8 && b < 12);
  endfunction

  function automatic logic [31:0] expRead(logic [2:0] a);
    case (a)
      3'd0: return {20'd0, mLoc};
      3'd1: return {20'd0, mEn};
      3'd2: return {30'd0, mGlo};
      3'd3: return {30'd0, mGse};
      3'd4: return {30'd0, mSig};
      default: return 32'd0;
    endcase
  endfunction

  // reference model: advances on each rising edge from the bench's own inputs
  always @(posedge clk) begin
    bit [11:0] nLoc;
    bit [1:0]  nGlo;
    bit        anyLoc;
    if (!rstN) begin
      mLoc = 0; mEn = 0; mGlo = 0; mGse = 0; mSig = 0; mIrq = 0;
    end else begin
      anyLoc = 0;
      for (int b = 0; b < 12; b++) if (mLoc[b] && mEn[b]) anyLoc = 1;
      mIrq = ((mGlo[0] && mSig[0]) || (mGlo[1] && mSig[1]));
      nLoc = mLoc;
      for (int b = 0; b < 12; b++) begin
        if (!implemented(b)) nLoc[b] = 0;
        else if (cardEvt[b]) nLoc[b] = 1;
        else if (wrEn && addr == 3'd0 && wrData[b]) nLoc[b] = 0;
      end
      nGlo = mGlo;
      if (wrEn && addr == 3'd2) nGlo = nGlo & ~wrData[1:0];
      if (anyLoc && mGse[0]) nGlo[0] = 1;
      if (sibReq && mGse[1]) nGlo[1] = 1;
      if (wrEn && addr == 3'd1)
        for (int b = 0; b < 12; b++) mEn[b] = implemented(b) ? wrData[b] : 1'b0;
      if (wrEn && addr == 3'd3) mGse = wrData[1:0];
      if (wrEn && addr == 3'd4) mSig = wrData[1:0];
      mLoc = nLoc;
      mGlo = nGlo;
    end
  end

  // comparison, away from the edge
  always @(posedge clk) begin
    #3;
    if (!done) begin
      checks++;
      if (irqOut !== mIrq) begin
        errors++;
        $display("FAIL %s irqOut act=%b exp=%b t=%0t", curReq, irqOut, mIrq, $time);
      end
      checks++;
      if (rdData !== expRead(addr)) begin
        errors++;
        $display("FAIL %s rdData@%0d act=%h exp=%h t=%0t", curReq, addr, rdData, expRead(addr), $time);
      end
    end
  end

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
  endtask

  task automatic look(input logic [2:0] a, input int n);
    @(negedge clk); addr = a;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [11:0] e);
    @(negedge clk); cardEvt = e;
    @(negedge clk); cardEvt = '0;
  endtask

  initial begin
    curReq = "R1";
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    look(3'd0, 2); look(3'd2, 1); look(3'd4, 1);

    curReq = "R2";
    for (int b = 0; b < 12; b++) begin
      pulse(12'(1 << b));
      look(3'd0, 1);
    end

    curReq = "R3";
    regWrite(3'd0, 32'h0000_0305);
    look(3'd0, 2);
    regWrite(3'd0, 32'h0000_0000);
    look(3'd0, 1);

    curReq = "R4";
    @(negedge clk); wrEn = 1; addr = 3'd0; wrData = 32'hFFF; cardEvt = 12'h401;
    @(negedge clk); wrEn = 0; wrData = 0; cardEvt = 0;
    look(3'd0, 2);

    curReq = "R10";
    regWrite(3'd1, 32'hFFFF_FFFF);
    look(3'd1, 1);
    regWrite(3'd5, 32'hFFFF_FFFF);
    regWrite(3'd6, 32'h0000_0003);
    regWrite(3'd7, 32'h0000_0FFF);
    look(3'd5, 1); look(3'd6, 1); look(3'd7, 1); look(3'd3, 1);

    curReq = "R5";
    look(3'd2, 3);
    regWrite(3'd3, 32'h1);
    look(3'd2, 3);

    curReq = "R6";
    regWrite(3'd3, 32'h1);
    @(negedge clk); sibReq = 1; @(negedge clk); sibReq = 0;
    look(3'd2, 2);
    regWrite(3'd3, 32'h3);
    @(negedge clk); sibReq = 1; @(negedge clk); sibReq = 0;
    look(3'd2, 2);

    curReq = "R7";
    regWrite(3'd2, 32'h3);
    look(3'd2, 2);
    regWrite(3'd0, 32'hFFF);
    regWrite(3'd2, 32'h1);
    look(3'd2, 2);

    curReq = "R8";
    regWrite(3'd4, 32'h2);
    @(negedge clk); sibReq = 1; @(negedge clk); sibReq = 0;
    look(3'd2, 3);
    regWrite(3'd2, 32'h2);
    look(3'd4, 3);
    pulse(12'h800);
    regWrite(3'd4, 32'h1);
    look(3'd2, 3);

    curReq = "R9";
    for (int i = 0; i < 16; i++) look(3'(i % 8), 1);

    curReq = "MIX R2 R3 R4 R7 R8";
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      wrEn    = ($urandom_range(0, 3) == 0);
      addr    = 3'($urandom_range(0, 7));
      wrData  = $urandom;
      cardEvt = ($urandom_range(0, 2) == 0) ? 12'($urandom) : 12'd0;
      sibReq  = ($urandom_range(0, 5) == 0);
    end
    @(negedge clk); wrEn = 0; cardEvt = 0; sibReq = 0;
    look(3'd2, 3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done = 1'b1;
    checks++;
    errors++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule